// File: doc/BRIEF.md
# GPIO Bank with Latched Pin Interrupts

A bank of general-purpose pins sitting on a simple register bus. Each pin has an output value and a drive-enable bit that together control its pad, and every pin level is brought back in through a two-flop synchroniser so software can read it at any time, whether or not the pin is driving.

Each pin also has an event detector. A per-pin mode bit selects edge or level detection, and a per-pin polarity bit selects which direction or level counts. Detected events are latched into a sticky status register. Software clears bits by writing ones to a clear location. A per-pin enable masks the status onto one registered summary interrupt line. Detection on both edges is not built in: software gets it by rewriting the polarity bit after each event.

The bus is plain control: a write strobe with address and data, and a read strobe whose data appears on `bus_rdata` in the cycle after the strobe. There is no back-pressure and no wait state.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output value, drive enable, interrupt enable and status registers read 0, the mode and polarity registers read all ones (rising-edge detection), `pad_out`, `pad_oe` and `irq` are 0.
- R2: Word address 0 holds the output value and address 7 the drive enable. A write to either is visible on `pad_out` / `pad_oe` and on readback from the next clock edge.
- R3: Address 1 reads the synchronised pin levels. A pad change is visible in reads issued two clock edges after it is applied, whatever the drive enable.
- R4: With mode bit (address 5) at 1, a pin's status bit is set by a transition in the direction chosen by its polarity bit (address 6: 1 rising, 0 falling); the opposite transition sets nothing.
- R5: With mode bit at 0, a status bit is set while the synchronised level equals the polarity bit, and it stays set after the level goes away until software clears it.
- R6: Writing to address 3 clears every status bit (address 2) whose data bit is 1; bits written 0 are unchanged. Address 3 reads as 0.
- R7: When a pin's detection condition holds in the same cycle as a clear of its status bit, the status bit stays set.
- R8: Status bits latch regardless of the interrupt enable (address 4). `irq` is one cycle behind the OR over pins of status AND enable.
- R9: Writes to the read-only addresses 1 and 2 have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, one cycle after the strobe |
| pad_in | input | PINS | Pin levels from the pads |
| pad_out | output | PINS | Output values to the pads |
| pad_oe | output | PINS | Drive enables to the pads |
| irq | output | 1 | Registered summary interrupt |

## Verification
The hardest case to reach from the ports is a status clear landing in exactly the cycle a detection is true. Edge events last one cycle and are hard to line up with a bus write, so the stimulus uses level mode instead: it holds a pin at its active level, which keeps the condition true every cycle, then issues the clear and confirms the bit survives. Releasing the level and clearing again shows that the clear itself works.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DOUT = 3'd0,
    SEL_DIN  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_IEN  = 3'd4,
    SEL_MODE = 3'd5,
    SEL_POL  = 3'd6,
    SEL_OE   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mode_edge,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] prev;
  logic [W-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, lvl_match;
    assign rise      = lvl[i] & ~prev[i];
    assign fall      = ~lvl[i] & prev[i];
    assign lvl_match = (lvl[i] == pol[i]);
    assign hit[i]    = mode_edge[i] ? (pol[i] ? rise : fall) : lvl_match;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= (status[i] & ~clr[i]) | hit[i];
    end

    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_edge[i] && (lvl[i] == pol[i])) |=> status[i]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr[i]) |=> status[i]);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && mode_edge[i] && lvl[i] == prev[i]) |=> !status[i]);
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_edge[i] && pol[i] && lvl[i] && !prev[i]) |=> status[i]);
  end
endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
  import gpb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      oe,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      mode_edge,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      clr
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  assign clr = (bus_we && sel == SEL_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      oe        <= '0;
      ien       <= '0;
      mode_edge <= '1;
      pol       <= '1;
    end else if (bus_we) begin
      case (sel)
        SEL_DOUT: dout      <= bus_wdata;
        SEL_OE:   oe        <= bus_wdata;
        SEL_IEN:  ien       <= bus_wdata;
        SEL_MODE: mode_edge <= bus_wdata;
        SEL_POL:  pol       <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (sel)
        SEL_DOUT: bus_rdata <= dout;
        SEL_DIN:  bus_rdata <= din;
        SEL_STAT: bus_rdata <= status;
        SEL_IEN:  bus_rdata <= ien;
        SEL_MODE: bus_rdata <= mode_edge;
        SEL_POL:  bus_rdata <= pol;
        SEL_OE:   bus_rdata <= oe;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd7) |=> (oe == $past(bus_wdata)));
  p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> (dout == $past(bus_wdata)));
  p_clr_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 3'd3) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpb_pkg::*;
#(
  parameter int PINS      = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  logic [PINS-1:0] lvl, status, ien, mode_edge, pol, clr;

  gpb_sync #(.W(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
  );

  gpb_regfile #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(lvl), .status(status),
    .dout(pad_out), .oe(pad_oe), .ien(ien),
    .mode_edge(mode_edge), .pol(pol), .clr(clr)
  );

  gpb_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode_edge(mode_edge),
    .pol(pol), .clr(clr), .status(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & ien);
  end

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ien)) |=> irq);
  p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & ien)) |=> !irq);
  p_keep_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~mode_edge & ~(lvl ^ pol))) |=> (|status));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int P = 16;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_we = 0, bus_re = 0;
  logic [2:0]   bus_addr = '0;
  logic [P-1:0] bus_wdata = '0, bus_rdata;
  logic [P-1:0] pad_in = '0, pad_out, pad_oe;
  logic         irq;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.PINS(P)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [P-1:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [P-1:0] d);
    bus_re = 1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [P-1:0] v;
    check("R1 pad_out", pad_out, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", irq, 0);
    rd(3'd0, v); check("R1 dout", v, 0);
    rd(3'd2, v); check("R1 status", v, 0);
    rd(3'd4, v); check("R1 ien", v, 0);
    rd(3'd5, v); check("R1 mode", v, 16'hFFFF);
    rd(3'd6, v); check("R1 pol", v, 16'hFFFF);
    rd(3'd7, v); check("R1 oe", v, 0);
  endtask

  task automatic t_outputs;
    logic [P-1:0] v;
    wr(3'd0, 16'hA5C3);
    check("R2 pad_out", pad_out, 16'hA5C3);
    wr(3'd7, 16'h0FF0);
    check("R2 pad_oe", pad_oe, 16'h0FF0);
    rd(3'd7, v); check("R2 oe readback", v, 16'h0FF0);
    rd(3'd0, v); check("R2 dout readback", v, 16'hA5C3);
  endtask

  task automatic t_input;
    logic [P-1:0] v;
    pad_in[15:12] = 4'b1010;
    cycles(2);
    rd(3'd1, v); check("R3 din with oe mixed", v, 16'hA000);
    wr(3'd7, 16'hFFFF);
    rd(3'd1, v); check("R3 din with oe all on", v, 16'hA000);
    pad_in[15:12] = 4'b0000;
    cycles(3);
    wr(3'd3, 16'hFFFF);
  endtask

  task automatic t_edge;
    logic [P-1:0] v;
    wr(3'd6, 16'hFFFD);            // pin1 falling, others rising
    pad_in[1] = 1; cycles(3);
    rd(3'd2, v); check("R4 opposite edge ignored", v, 0);
    pad_in[1] = 0; cycles(3);
    rd(3'd2, v); check("R4 falling edge", v, 16'h0002);
    pad_in[2] = 1; cycles(3);
    rd(3'd2, v); check("R4 rising edge", v, 16'h0006);
    check("R8 irq gated off", irq, 0);
    wr(3'd4, 16'h0004);
    cycles(1);
    check("R8 irq raised", irq, 1);
    wr(3'd3, 16'h0000);
    rd(3'd2, v); check("R6 zero clear no effect", v, 16'h0006);
    rd(3'd3, v); check("R6 clear reads 0", v, 0);
    wr(3'd3, 16'h0004);
    rd(3'd2, v); check("R6 clear bit2", v, 16'h0002);
    check("R8 irq dropped", irq, 0);
    wr(3'd3, 16'h0002);
    pad_in[2] = 0; cycles(3);
  endtask

  task automatic t_level;
    logic [P-1:0] v;
    wr(3'd5, 16'hFFFE);            // pin0 level, pol high (reset value)
    cycles(2);
    rd(3'd2, v); check("R5 inactive level no event", v, 0);
    pad_in[0] = 1; cycles(3);
    rd(3'd2, v); check("R5 level latched", v, 16'h0001);
    wr(3'd3, 16'h0001);            // condition still true in this cycle
    rd(3'd2, v); check("R7 clear loses to live level", v, 16'h0001);
    pad_in[0] = 0; cycles(4);
    rd(3'd2, v); check("R5 sticky after level gone", v, 16'h0001);
    wr(3'd3, 16'h0001);
    rd(3'd2, v); check("R6 clear after release", v, 0);
  endtask

  task automatic t_readonly;
    logic [P-1:0] v;
    pad_in[8] = 1; cycles(3);
    wr(3'd3, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); check("R9 status write ignored", v, 0);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R9 din write ignored", v, 16'h0100);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(2);
    t_reset;
    t_outputs;
    t_input;
    t_edge;
    t_level;
    t_readonly;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule